// File: doc/BRIEF.md
# NAND Flash Command Front End

This block sits at the pin side of a NAND flash die and turns the bus cycles that arrive on the shared 8-bit I/O port into decoded work for the die's operation controller. A bus cycle is taken when the active-low write strobe returns high while chip enable is asserted. The two latch-enable inputs decide what the byte is: a command when the command latch enable is high, an address byte when the address latch enable is high, and a program data byte when both are low. All pins are assumed to be already synchronous to `clk`.

The front end tracks where each command sequence stands. Page reads take three address bytes: the column first, then the low row byte, then the high row byte. Page programming is a setup, three address bytes, a run of data bytes and a confirm. Block erase is a setup, two row bytes and a confirm. The identification read takes one address byte. Status read and reset act at once. When a sequence completes, the block sends a one-cycle request carrying an opcode and the assembled 24-bit address. Each accepted program data byte goes out on its own one-cycle strobe. While the controller reports busy, only status read and reset are let through.

Top module: `nand_cmd_front`

## Requirements
- R1: After reset no strobe is active and the read pointer selects the lower main half (read mode). Three address cycles with no command before them issue a read request with opcode 0.
- R2: A cycle is taken only on a rising edge of `weN` while `ceN` is low. A cycle with `cle` and `ale` both high does nothing.
- R3: Commands 00h, 01h and 50h, each followed by three address bytes (column, low row, high row), issue one request on the third byte. The opcode is 0, 1 or 2 respectively, and `reqAddr` is {high row, low row, column}. Opcodes: 0 read lower half, 1 read upper half, 2 read spare, 3 program, 4 erase, 5 read ID, 6 status, 7 reset.
- R4: After a read request, a further three address bytes issue another read without a new command. After an opcode-1 read, the pointer falls back to opcode 0. The spare pointer (opcode 2) persists.
- R5: After 80h and three address bytes, each data cycle gives a one-cycle `dataValid` carrying the bus byte, for at most 528 bytes. Data beyond that is dropped. A following 10h issues opcode 3 with the R3 address layout.
- R6: 10h issues nothing unless 80h and all three of its address bytes came before it.
- R7: 60h, then two row bytes (low row, high row), then D0h issues opcode 4 with `reqAddr` = {high row, low row with bits 3:0 cleared, 00h}. D0h at any other point issues nothing.
- R8: 90h followed by one address byte issues opcode 5 with `reqAddr` = {16'h0, that byte}.
- R9: 70h issues opcode 6 at once and FFh issues opcode 7 at once, both with `reqAddr` zero. After 70h, address bytes issue nothing until a read command. Reset restores the R1 read pointer.
- R10: While `busy` is high, every cycle other than the 70h and FFh commands is ignored.
- R11: With `busy` low, `ceN` high abandons a partly entered sequence. With `busy` high, `ceN` high leaves the sequence intact.
- R12: A command byte outside the supported set leaves the sequence state unchanged. So does an address or data byte arriving where none is expected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write strobe, active low; the cycle is taken on its rising edge |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| ioIn | input | 8 | Multiplexed command/address/data byte |
| busy | input | 1 | Operation controller busy with an array operation |
| reqValid | output | 1 | One-cycle request strobe |
| reqOp | output | 3 | Request opcode (see R3) |
| reqAddr | output | 24 | Assembled request address |
| dataValid | output | 1 | One-cycle program data strobe |
| dataByte | output | 8 | Program data byte |

## Verification
Two things can fall on the same write cycle. The final address byte of a read or identification sequence has to be stored and also used in the request that goes out on that cycle. Separately, the busy level sampled in that cycle decides whether the byte counts at all. The bench drives random addresses so that the last byte has to appear in `reqAddr` on the strobe that follows it. It also raises `busy` in the cycle before a sequence byte, and around `ceN` pulses, then checks that only status and reset get through and that the sequence held across the busy window still completes.

// File: rtl/nand_cmd_pkg.sv
package nand_cmd_pkg;

  typedef enum logic [2:0] {
    OP_READ_LO  = 3'd0,
    OP_READ_HI  = 3'd1,
    OP_READ_SP  = 3'd2,
    OP_PROGRAM  = 3'd3,
    OP_ERASE    = 3'd4,
    OP_READ_ID  = 3'd5,
    OP_STATUS   = 3'd6,
    OP_RESET    = 3'd7
  } reqOp_e;

  localparam logic [7:0] CMD_RD_LO   = 8'h00;
  localparam logic [7:0] CMD_RD_HI   = 8'h01;
  localparam logic [7:0] CMD_RD_SP   = 8'h50;
  localparam logic [7:0] CMD_PG_SET  = 8'h80;
  localparam logic [7:0] CMD_PG_GO   = 8'h10;
  localparam logic [7:0] CMD_ER_SET  = 8'h60;
  localparam logic [7:0] CMD_ER_GO   = 8'hD0;
  localparam logic [7:0] CMD_ID      = 8'h90;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_RESET   = 8'hFF;

  // strobes from control to datapath for one bus cycle
  typedef struct packed {
    logic       loadAddr;
    logic       clearAddr;
    logic [1:0] addrIdx;
    logic       issue;
    reqOp_e     op;
    logic       emitData;
  } ctrlStrobes_t;

endpackage

// File: rtl/nand_cmd_datapath.sv
module nand_cmd_datapath
  import nand_cmd_pkg::*;
#(
  parameter int IO_W          = 8,
  parameter int ADDR_CYCLES   = 3,
  parameter int PAGE_SEL_BITS = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [IO_W-1:0]             ioIn,
  input  ctrlStrobes_t                strb,
  output logic                        reqValid,
  output reqOp_e                      reqOp,
  output logic [ADDR_CYCLES*IO_W-1:0] reqAddr,
  output logic                        dataValid,
  output logic [IO_W-1:0]             dataByte
);

  localparam int AW = ADDR_CYCLES * IO_W;

  logic [IO_W-1:0] addrByte [ADDR_CYCLES];
  logic [AW-1:0]   assembled;
  logic [AW-1:0]   masked;

  for (genvar i = 0; i < ADDR_CYCLES; i++) begin : g_addr
    logic hit;
    assign hit = strb.loadAddr && (int'(strb.addrIdx) == i);

    always_ff @(posedge clk) begin
      if (!rstN || strb.clearAddr) addrByte[i] <= '0;
      else if (hit)                addrByte[i] <= ioIn;
    end

    // the byte taken in this cycle goes into the request of this cycle
    assign assembled[i*IO_W +: IO_W] = strb.clearAddr ? '0 :
                                       hit ? ioIn : addrByte[i];
  end

  always_comb begin
    masked = assembled;
    if (strb.op == OP_ERASE) begin
      masked[IO_W-1:0]                = '0;
      masked[IO_W +: PAGE_SEL_BITS]   = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqValid  <= 1'b0;
      reqOp     <= OP_READ_LO;
      reqAddr   <= '0;
      dataValid <= 1'b0;
      dataByte  <= '0;
    end else begin
      reqValid  <= strb.issue;
      dataValid <= strb.emitData;
      if (strb.issue) begin
        reqOp   <= strb.op;
        reqAddr <= masked;
      end
      if (strb.emitData) dataByte <= ioIn;
    end
  end

endmodule

// File: rtl/nand_cmd_control.sv
module nand_cmd_control
  import nand_cmd_pkg::*;
#(
  parameter int IO_W        = 8,
  parameter int ADDR_CYCLES = 3,
  parameter int PAGE_BYTES  = 528
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ceN,
  input  logic            weN,
  input  logic            cle,
  input  logic            ale,
  input  logic [IO_W-1:0] ioIn,
  input  logic            busy,
  output ctrlStrobes_t    strb
);

  localparam int DW = $clog2(PAGE_BYTES + 1);
  localparam logic [DW-1:0] DATA_LIMIT = DW'(PAGE_BYTES);
  localparam logic [1:0]    LAST_IDX   = 2'(ADDR_CYCLES - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_RD_ADDR, S_PG_ADDR, S_PG_DATA, S_ER_ADDR, S_ER_CONF, S_ID_ADDR
  } seqState_e;

  seqState_e state, stateN;
  logic [1:0]    addrCnt, addrCntN;
  logic [1:0]    readPtr, readPtrN;
  logic          readMode, readModeN;
  logic [DW-1:0] dataCnt, dataCntN;
  logic          weNQ;
  logic          cycEv, cmdEv, addrEv, dataEv;

  assign cycEv  = weN && !weNQ && !ceN;
  assign cmdEv  = cycEv && cle && !ale;
  assign addrEv = cycEv && ale && !cle;
  assign dataEv = cycEv && !cle && !ale;

  always_comb begin
    strb      = '0;
    stateN    = state;
    addrCntN  = addrCnt;
    readPtrN  = readPtr;
    readModeN = readMode;
    dataCntN  = dataCnt;
    if (cmdEv && ioIn == CMD_STATUS) begin
      strb.issue = 1'b1; strb.op = OP_STATUS; strb.clearAddr = 1'b1;
      stateN = S_IDLE; readModeN = 1'b0;
    end else if (cmdEv && ioIn == CMD_RESET) begin
      strb.issue = 1'b1; strb.op = OP_RESET; strb.clearAddr = 1'b1;
      stateN = S_IDLE; readModeN = 1'b1; readPtrN = 2'd0;
    end else if (cmdEv && !busy) begin
      case (ioIn)
        CMD_RD_LO, CMD_RD_HI, CMD_RD_SP: begin
          readPtrN  = (ioIn == CMD_RD_LO) ? 2'd0 : (ioIn == CMD_RD_HI) ? 2'd1 : 2'd2;
          readModeN = 1'b1; stateN = S_RD_ADDR; addrCntN = 2'd0;
        end
        CMD_PG_SET: begin stateN = S_PG_ADDR; addrCntN = 2'd0; strb.clearAddr = 1'b1; end
        CMD_ER_SET: begin stateN = S_ER_ADDR; addrCntN = 2'd0; strb.clearAddr = 1'b1; end
        CMD_ID:     begin stateN = S_ID_ADDR; strb.clearAddr = 1'b1; end
        CMD_PG_GO: if (state == S_PG_DATA) begin
          strb.issue = 1'b1; strb.op = OP_PROGRAM; stateN = S_IDLE; readModeN = 1'b0;
        end
        CMD_ER_GO: if (state == S_ER_CONF) begin
          strb.issue = 1'b1; strb.op = OP_ERASE; stateN = S_IDLE; readModeN = 1'b0;
        end
        default: ;
      endcase
    end else if (addrEv && !busy) begin
      case (state)
        S_IDLE: if (readMode) begin
          strb.loadAddr = 1'b1; strb.addrIdx = 2'd0;
          stateN = S_RD_ADDR; addrCntN = 2'd1;
        end
        S_RD_ADDR: begin
          strb.loadAddr = 1'b1; strb.addrIdx = addrCnt;
          addrCntN = addrCnt + 2'd1;
          if (addrCnt == LAST_IDX) begin
            strb.issue = 1'b1; strb.op = reqOp_e'({1'b0, readPtr});
            stateN = S_IDLE;
            if (readPtr == 2'd1) readPtrN = 2'd0;
          end
        end
        S_PG_ADDR: begin
          strb.loadAddr = 1'b1; strb.addrIdx = addrCnt;
          addrCntN = addrCnt + 2'd1;
          if (addrCnt == LAST_IDX) begin stateN = S_PG_DATA; dataCntN = '0; end
        end
        S_ER_ADDR: begin
          strb.loadAddr = 1'b1; strb.addrIdx = addrCnt + 2'd1;
          addrCntN = addrCnt + 2'd1;
          if (addrCnt + 2'd1 == LAST_IDX) stateN = S_ER_CONF;
        end
        S_ID_ADDR: begin
          strb.loadAddr = 1'b1; strb.addrIdx = 2'd0;
          strb.issue = 1'b1; strb.op = OP_READ_ID;
          stateN = S_IDLE; readModeN = 1'b0;
        end
        default: ;
      endcase
    end else if (dataEv && !busy) begin
      if (state == S_PG_DATA && dataCnt < DATA_LIMIT) begin
        strb.emitData = 1'b1; dataCntN = dataCnt + 1'b1;
      end
    end else if (ceN && !busy) begin
      stateN = S_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      addrCnt  <= '0;
      readPtr  <= 2'd0;
      readMode <= 1'b1;
      dataCnt  <= '0;
      weNQ     <= 1'b1;
    end else begin
      state    <= stateN;
      addrCnt  <= addrCntN;
      readPtr  <= readPtrN;
      readMode <= readModeN;
      dataCnt  <= dataCntN;
      weNQ     <= weN;
    end
  end

endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
  import nand_cmd_pkg::*;
#(
  parameter int IO_W          = 8,
  parameter int ADDR_CYCLES   = 3,
  parameter int PAGE_BYTES    = 528,
  parameter int PAGE_SEL_BITS = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        ceN,
  input  logic                        weN,
  input  logic                        cle,
  input  logic                        ale,
  input  logic [IO_W-1:0]             ioIn,
  input  logic                        busy,
  output logic                        reqValid,
  output logic [2:0]                  reqOp,
  output logic [ADDR_CYCLES*IO_W-1:0] reqAddr,
  output logic                        dataValid,
  output logic [IO_W-1:0]             dataByte
);

  ctrlStrobes_t strb;
  reqOp_e       opQ;

  nand_cmd_control #(
    .IO_W(IO_W), .ADDR_CYCLES(ADDR_CYCLES), .PAGE_BYTES(PAGE_BYTES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .cle(cle), .ale(ale),
    .ioIn(ioIn), .busy(busy), .strb(strb)
  );

  nand_cmd_datapath #(
    .IO_W(IO_W), .ADDR_CYCLES(ADDR_CYCLES), .PAGE_SEL_BITS(PAGE_SEL_BITS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ioIn(ioIn), .strb(strb),
    .reqValid(reqValid), .reqOp(opQ), .reqAddr(reqAddr),
    .dataValid(dataValid), .dataByte(dataByte)
  );

  assign reqOp = opQ;

endmodule

// File: rtl/nand_cmd_front_chk.sv
module nand_cmd_front_chk (
  input logic        clk,
  input logic        rstN,
  input logic        ceN,
  input logic        cle,
  input logic        ale,
  input logic [7:0]  ioIn,
  input logic        busy,
  input logic        reqValid,
  input logic [2:0]  reqOp,
  input logic [23:0] reqAddr,
  input logic        dataValid,
  input logic [7:0]  dataByte
);

  // R2
  req_data_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && dataValid));

  // R2
  req_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> !reqValid);

  // R5
  data_from_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> (dataByte == $past(ioIn) && !$past(cle) && !$past(ale) && !$past(ceN)));

  // R10
  busy_filter_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && $past(busy)) |-> (reqOp == 3'd6 || reqOp == 3'd7));

  // R7
  erase_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 3'd4) |-> (reqAddr[11:0] == 12'h000));

  // R9
  immediate_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqOp == 3'd6 || reqOp == 3'd7)) |-> (reqAddr == 24'h0 && $past(cle)));

endmodule

bind nand_cmd_front nand_cmd_front_chk chk_i (
  .clk(clk), .rstN(rstN), .ceN(ceN), .cle(cle), .ale(ale), .ioIn(ioIn),
  .busy(busy), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
  .dataValid(dataValid), .dataByte(dataByte)
);

// File: tb/nand_cmd_front_tb.sv
module nand_cmd_front_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, weN = 1'b1, cle = 1'b0, ale = 1'b0, busy = 1'b0;
  logic [7:0] ioIn = 8'h00;
  logic reqValid, dataValid;
  logic [2:0] reqOp;
  logic [23:0] reqAddr;
  logic [7:0] dataByte;

  int nChecks = 0, nFails = 0, cyc = 0;
  logic gReq, gDv;
  logic [2:0] gOp;
  logic [23:0] gAddr;
  logic [7:0] gByte;

  always #10 clk = ~clk;

  nand_cmd_front dut_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .cle(cle), .ale(ale),
    .ioIn(ioIn), .busy(busy), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .dataValid(dataValid), .dataByte(dataByte)
  );

  function automatic logic [23:0] readAddr(logic [7:0] c, l, h);
    return {h, l, c};
  endfunction

  function automatic logic [23:0] eraseAddr(logic [7:0] l, h);
    return {h, l & 8'hF0, 8'h00};
  endfunction

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(logic c, logic a, logic [7:0] b, logic ce = 1'b0);
    @(negedge clk); ceN = ce; cle = c; ale = a; ioIn = b; weN = 1'b0;
    @(negedge clk); weN = 1'b1;
    @(negedge clk);
    gReq = reqValid; gOp = reqOp; gAddr = reqAddr; gDv = dataValid; gByte = dataByte;
    cle = 1'b0; ale = 1'b0; ceN = 1'b0;
  endtask

  task automatic cmd(logic [7:0] b);  wr(1'b1, 1'b0, b); endtask
  task automatic adr(logic [7:0] b);  wr(1'b0, 1'b1, b); endtask
  task automatic dat(logic [7:0] b);  wr(1'b0, 1'b0, b); endtask

  task automatic expReq(string r, logic [2:0] op, logic [23:0] a);
    check(r, {31'd0, gReq}, 32'd1);
    check(r, {29'd0, gOp}, {29'd0, op});
    check(r, {8'd0, gAddr}, {8'd0, a});
  endtask

  task automatic expNone(string r);
    check(r, {30'd0, gReq, gDv}, 32'd0);
  endtask

  task automatic rdTriple(string r, logic [7:0] c, l, h, logic [2:0] op);
    adr(c); expNone(r); adr(l); expNone(r); adr(h);
    expReq(r, op, readAddr(c, l, h));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nFails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int unsigned seedv;
    int cnt;
    logic [7:0] c, l, h, b;
    seedv = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset", {30'd0, reqValid, dataValid}, 32'd0);

    // R1 default read mode
    rdTriple("R1", 8'h12, 8'h34, 8'h56, 3'd0);
    // R4 repeat without command
    rdTriple("R4", 8'h01, 8'h02, 8'h03, 3'd0);
    // R3 upper half, then R4 fallback
    cmd(8'h01); expNone("R3");
    rdTriple("R3", 8'hAA, 8'hBB, 8'hCC, 3'd1);
    rdTriple("R4", 8'h0F, 8'h1E, 8'h2D, 3'd0);
    cmd(8'h50);
    rdTriple("R3", 8'h05, 8'h66, 8'h77, 3'd2);
    rdTriple("R4", 8'h03, 8'h44, 8'h01, 3'd2);
    cmd(8'h00);
    // R2 both latch enables high, and chip enable high
    wr(1'b1, 1'b1, 8'h70); expNone("R2");
    wr(1'b1, 1'b0, 8'h70, 1'b1); expNone("R2");

    // R5 random program sequences, R3 layout
    for (int i = 0; i < 20; i++) begin
      c = 8'($urandom); l = 8'($urandom); h = 8'($urandom);
      cmd(8'h80); adr(c); adr(l); adr(h); expNone("R5");
      cnt = 1 + int'($urandom % 5);
      for (int k = 0; k < cnt; k++) begin
        b = 8'($urandom); dat(b);
        check("R5", {31'd0, gDv}, 32'd1);
        check("R5", {24'd0, gByte}, {24'd0, b});
      end
      cmd(8'h10); expReq("R5", 3'd3, readAddr(c, l, h));
    end

    // R6 confirm without complete setup
    cmd(8'h10); expNone("R6");
    cmd(8'h80); adr(8'h11); adr(8'h22); cmd(8'h10); expNone("R6");
    adr(8'h33); dat(8'h9C); check("R6", {31'd0, gDv}, 32'd1);
    // R12 unknown command inside program keeps state
    cmd(8'h33); expNone("R12");
    dat(8'h5A); check("R12", {24'd0, gByte}, 32'h5A);
    adr(8'h44); expNone("R12");
    cmd(8'h10); expReq("R6", 3'd3, readAddr(8'h11, 8'h22, 8'h33));

    // R7 random erase
    for (int i = 0; i < 10; i++) begin
      l = 8'($urandom); h = 8'($urandom);
      cmd(8'h60); adr(l); expNone("R7"); adr(h); expNone("R7");
      cmd(8'hD0); expReq("R7", 3'd4, eraseAddr(l, h));
    end
    cmd(8'hD0); expNone("R7");
    cmd(8'h60); adr(8'h1F); cmd(8'hD0); expNone("R7");

    // R8 read ID, then R12 addresses ignored
    cmd(8'h90); expNone("R8");
    adr(8'h00); expReq("R8", 3'd5, 24'h0);
    adr(8'h01); adr(8'h02); adr(8'h03); expNone("R12");

    // R9 status and following address ignored
    cmd(8'h70); expReq("R9", 3'd6, 24'h0);
    adr(8'h01); adr(8'h02); adr(8'h03); expNone("R9");

    // R10 busy filtering
    cmd(8'h50);
    @(negedge clk); busy = 1'b1;
    cmd(8'h01); adr(8'h09); adr(8'h08); adr(8'h07); expNone("R10");
    cmd(8'h80); dat(8'h12); expNone("R10");
    cmd(8'h70); expReq("R10", 3'd6, 24'h0);
    cmd(8'hFF); expReq("R10", 3'd7, 24'h0);
    @(negedge clk); busy = 1'b0;
    rdTriple("R9", 8'h21, 8'h43, 8'h65, 3'd0);

    // R11 chip enable high abandons when idle
    cmd(8'h80); adr(8'h01); adr(8'h02); adr(8'h03);
    @(negedge clk); ceN = 1'b1; @(negedge clk); ceN = 1'b0;
    dat(8'h77); expNone("R11");
    cmd(8'h10); expNone("R11");
    // R11 held while busy
    cmd(8'h80); adr(8'hC1); adr(8'hC2); adr(8'hC3);
    @(negedge clk); busy = 1'b1;
    @(negedge clk); ceN = 1'b1; repeat (3) @(negedge clk); ceN = 1'b0;
    @(negedge clk); busy = 1'b0;
    dat(8'hE4); check("R11", {31'd0, gDv}, 32'd1);
    cmd(8'h10); expReq("R11", 3'd3, readAddr(8'hC1, 8'hC2, 8'hC3));

    // R5 page limit
    cmd(8'h80); adr(8'h00); adr(8'h00); adr(8'h00);
    cnt = 0;
    for (int k = 0; k < 530; k++) begin
      dat(8'(k)); if (gDv) cnt++;
    end
    check("R5 limit", cnt, 32'd528);
    cmd(8'h10); expReq("R5", 3'd3, 24'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule